// File: doc/BRIEF.md
# Sampled Quadrature Encoder Decoder

This block turns the two phase lines of a rotary encoder into a stream of single-cycle step events and a signed position count. Both phase lines first pass through a synchroniser chain. A periodic sample strobe from elsewhere in the chip then decides when the synchronised pair is examined. The strobe runs slower than the system clock. It must still be fast enough that every intermediate quadrature state is seen.

On each strobe, the block compares the sampled pair with the pair it stored at the last step. If the two differ, it does four things:

- emits a one-cycle step pulse with a direction bit,
- moves a 16-bit wrapping two's-complement position by one,
- replaces the stored pair,
- sets a sticky changed flag that stays up until the consumer clears it.

Direction is found by comparing the new phase A with the phase B that was stored. Every transition counts, so a full detent moves the position by four. A jump in which both bits change is not flagged as an error; it still produces a step by the same rule. Swapping the lines or inverting their polarity only changes which way counts as up.

Top module: `qdec_top`

## Requirements
- R1: After reset, step_o, dir_o and changed_o are 0, pos_o is 0, and the stored state is {A,B}=2'b00.
- R2: When tick_i is high at a clock edge and the synchronised state {A,B} differs from the stored state, step_o is high for exactly the one cycle after that edge, and pos_o and dir_o take their new values at the same edge.
- R3: No step occurs and pos_o is unchanged when tick_i samples a state equal to the stored one, or when the phases change but tick_i stays low.
- R4: Forward motion increments pos_o by one per transition with dir_o=1. Forward means new A equals stored B, which gives the state order {A,B} 00→01→11→10→00.
- R5: Reverse motion decrements pos_o by one per transition with dir_o=0. Reverse means new A differs from stored B, which gives the order 00→10→11→01→00.
- R6: One full detent of four transitions moves pos_o by exactly four in either direction.
- R7: A transition in which both bits change still yields a step by the same rule: 00→11 steps reverse (decrement), and 01→10 steps forward (increment).
- R8: pos_o wraps modulo 2^16: decrementing from 0 gives 16'hFFFF, and incrementing from 16'hFFFF gives 0.
- R9: changed_o is set at every position update and stays set, across further ticks without change, until flag_clr_i is high at a clock edge with no update; after that edge it reads 0.
- R10: If flag_clr_i is high in the same cycle as an update, changed_o stays 1.
- R11: Phase inputs pass through two synchroniser flops. If a phase change is applied just after one clock edge and tick_i is high at the very next edge, no step results. The same state is seen by a tick two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_a_i | input | 1 | Encoder phase A, asynchronous |
| phase_b_i | input | 1 | Encoder phase B, asynchronous |
| tick_i | input | 1 | Periodic sample strobe, one cycle wide |
| flag_clr_i | input | 1 | Clears the changed flag |
| step_o | output | 1 | One-cycle pulse per counted transition |
| dir_o | output | 1 | Direction of the last step, 1 = forward |
| pos_o | output | 16 | Signed position, wraps |
| changed_o | output | 1 | Sticky flag, set on every position update |

## Verification
Two situations are hard to reach: a flag clear that coincides with an update, and a tick that falls inside the synchroniser latency. The bench drives phases and strobe on the falling edge, so it can place each strobe at a chosen rising edge relative to the phase change. It raises flag_clr_i in the same cycle as an updating tick to cover the clear-versus-update case. It fires a tick exactly one edge after a phase change to show the change is not yet visible. Wrap-around is reached by reverse steps starting from the reset value of zero.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  localparam int unsigned POS_W = 16;

  typedef logic [1:0] qstate_t;   // {A,B}

  // 1 = forward: new A equals previously stored B
  function automatic logic qd_is_fwd(input qstate_t cur, input qstate_t prev);
    return ~(cur[1] ^ prev[0]);
  endfunction

  function automatic logic [POS_W-1:0] qd_next_pos(input logic [POS_W-1:0] pos,
                                                   input logic fwd);
    return fwd ? pos + 1'b1 : pos - 1'b1;
  endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/qdec_step.sv
module qdec_step
  import qdec_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  qstate_t cur_i,
  input  logic    tick_i,
  output logic    fire_o,
  output logic    fwd_o,
  output logic    step_o,
  output logic    dir_o
);
  qstate_t prev_q;
  logic    differ_w;

  assign differ_w = (cur_i != prev_q);
  assign fire_o   = tick_i & differ_w;
  assign fwd_o    = qd_is_fwd(cur_i, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 2'b00;
      step_o <= 1'b0;
      dir_o  <= 1'b0;
    end else begin
      step_o <= fire_o;
      if (fire_o) begin
        prev_q <= cur_i;
        dir_o  <= fwd_o;
      end
    end
  end

  // R2
  step_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> $past(tick_i));

  // R3
  no_step_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && cur_i == prev_q) |=> !step_o);

  // R2
  prev_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> prev_q == $past(cur_i));
endmodule

// File: rtl/qdec_pos.sv
module qdec_pos
  import qdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic             fwd_i,
  input  logic             clr_i,
  output logic [POS_W-1:0] pos_o,
  output logic             changed_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_o     <= '0;
      changed_o <= 1'b0;
    end else begin
      if (fire_i) begin
        pos_o     <= qd_next_pos(pos_o, fwd_i);
        changed_o <= 1'b1;
      end else if (clr_i) begin
        changed_o <= 1'b0;
      end
    end
  end

  // R4
  pos_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && fwd_i) |=> pos_o == $past(pos_o) + 16'd1);

  // R5
  pos_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !fwd_i) |=> pos_o == $past(pos_o) - 16'd1);

  // R3
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |=> $stable(pos_o));

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> changed_o);

  // R9
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !fire_i) |=> !changed_o);
endmodule

// File: rtl/qdec_top.sv
module qdec_top
  import qdec_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a_i,
  input  logic             phase_b_i,
  input  logic             tick_i,
  input  logic             flag_clr_i,
  output logic             step_o,
  output logic             dir_o,
  output logic [POS_W-1:0] pos_o,
  output logic             changed_o
);
  qstate_t cur_w;
  logic    fire_w;
  logic    fwd_w;

  qdec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({phase_a_i, phase_b_i}),
    .sync_o  (cur_w)
  );

  qdec_step u_step (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur_i  (cur_w),
    .tick_i (tick_i),
    .fire_o (fire_w),
    .fwd_o  (fwd_w),
    .step_o (step_o),
    .dir_o  (dir_o)
  );

  qdec_pos u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (fire_w),
    .fwd_i     (fwd_w),
    .clr_i     (flag_clr_i),
    .pos_o     (pos_o),
    .changed_o (changed_o)
  );

  // R2
  step_matches_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> changed_o);
endmodule

// File: tb/test_qdec_top.sv
module test_qdec_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pa = 1'b0, pb = 1'b0, tick = 1'b0, clr = 1'b0;
  logic        step, dir, changed;
  logic [15:0] pos;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] exp_pos = 16'd0;
  logic [1:0]  exp_prev = 2'b00;

  always #10 clk = ~clk;   // 50 MHz

  qdec_top i_qdec_top (
    .clk(clk), .rst_n(rst_n), .phase_a_i(pa), .phase_b_i(pb),
    .tick_i(tick), .flag_clr_i(clr),
    .step_o(step), .dir_o(dir), .pos_o(pos), .changed_o(changed)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model of the direction rule
  function automatic logic model_fwd(input logic [1:0] nw, input logic [1:0] old);
    return nw[1] == old[0];
  endfunction

  // drive state, let synchroniser settle, strobe once; ends at the
  // falling edge right after the sampling edge
  task automatic move(input string req, input logic [1:0] st);
    logic f;
    @(negedge clk); {pa, pb} = st;
    repeat (3) @(negedge clk);
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    if (st != exp_prev) begin
      f = model_fwd(st, exp_prev);
      exp_pos = f ? exp_pos + 16'd1 : exp_pos - 16'd1;
      exp_prev = st;
      check({req, " step"}, step, 1);
      check({req, " dir"}, dir, f);
    end else begin
      check({req, " no step"}, step, 0);
    end
    check({req, " pos"}, pos, exp_pos);
    @(negedge clk);
    check({req, " pulse one cycle"}, step, 0);
  endtask

  task automatic t_reset;
    check("R1 step", step, 0);
    check("R1 dir", dir, 0);
    check("R1 pos", pos, 0);
    check("R1 changed", changed, 0);
  endtask

  task automatic t_wrap;   // starting at pos 0, state 00
    move("R8 down", 2'b10);
    check("R8 wrap to FFFF", pos, 16'hFFFF);
    move("R8 up", 2'b00);
    check("R8 wrap to 0", pos, 16'h0000);
  endtask

  task automatic t_flag_clear;
    check("R9 set after step", changed, 1);
    move("R9 idle tick", exp_prev);
    check("R9 sticky", changed, 1);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R9 cleared", changed, 0);
  endtask

  task automatic t_forward;
    logic [15:0] p0;
    p0 = pos;
    move("R4 fwd", 2'b01);
    move("R4 fwd", 2'b11);
    move("R4 fwd", 2'b10);
    move("R4 fwd", 2'b00);
    check("R6 detent +4", pos, p0 + 16'd4);
  endtask

  task automatic t_reverse;
    logic [15:0] p0;
    p0 = pos;
    move("R5 rev", 2'b10);
    move("R5 rev", 2'b11);
    move("R5 rev", 2'b01);
    move("R5 rev", 2'b00);
    check("R6 detent -4", pos, p0 - 16'd4);
  endtask

  task automatic t_no_tick;
    logic [15:0] p0;
    p0 = pos;
    @(negedge clk); {pa, pb} = 2'b01;
    repeat (6) begin
      @(negedge clk);
      check("R3 no tick no step", step, 0);
    end
    check("R3 no tick pos", pos, p0);
    @(negedge clk); {pa, pb} = exp_prev;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_double;   // from state 00
    move("R7 00->11 rev", 2'b11);
    move("R7 to 01", 2'b01);
    move("R7 01->10 fwd", 2'b10);
    move("R7 back", 2'b00);
  endtask

  task automatic t_clr_collide;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R10 pre clear", changed, 0);
    @(negedge clk); {pa, pb} = 2'b01;
    repeat (3) @(negedge clk);
    tick = 1'b1; clr = 1'b1;
    @(negedge clk); tick = 1'b0; clr = 1'b0;
    exp_pos = exp_pos + 16'd1; exp_prev = 2'b01;
    check("R10 step", step, 1);
    check("R10 flag kept", changed, 1);
    move("R10 return", 2'b00);
  endtask

  task automatic t_sync_latency;
    logic [15:0] p0;
    p0 = pos;
    @(negedge clk); {pa, pb} = 2'b01;
    tick = 1'b1;            // sampled at the first edge after the change
    @(negedge clk); tick = 1'b0;
    check("R11 first edge no step", step, 0);
    tick = 1'b1;            // sampled at the second edge
    @(negedge clk); tick = 1'b0;
    check("R11 second edge no step", step, 0);
    check("R11 pos held", pos, p0);
    tick = 1'b1;            // third edge: synchronised value now visible
    @(negedge clk); tick = 1'b0;
    exp_pos = exp_pos + 16'd1; exp_prev = 2'b01;
    check("R11 seen later", step, 1);
    check("R11 pos", pos, exp_pos);
    move("R11 return", 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    move("R3 same state", 2'b00);
    t_wrap();
    t_flag_clear();
    t_forward();
    t_reverse();
    move("R2 single", 2'b01);
    move("R2 back", 2'b00);
    t_no_tick();
    t_double();
    t_clr_collide();
    t_sync_latency();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule